// File: doc/BRIEF.md
# Bidirectional GPIO Port with PWM Pin Override

This block is an eight-pin general-purpose I/O port reached through a byte-wide, single-cycle register bus. Three registers control it: a pin-value latch, a direction register and a PWM takeover register. A pin whose direction bit is set drives the latched value. A pin whose direction bit is clear is released to high impedance, and its level is read back through a two-flop synchronizer.

Each bit of the takeover register can hand its pin to an external PWM waveform bit. That pin is then driven with the waveform whatever its direction bit says. The block drives a per-pin output value and a per-pin output enable for a tristate pad. It does not generate the PWM waveforms.

Top module: `gpio_pwm_port`

## Requirements
- R1: After reset the pin-value latch, direction register and takeover register all read 0x00, and every `pad_oe` bit is 0.
- R2: A bus write to address 0x01 (pin-value register) loads the latch in the next clock edge, whatever the direction bits are. A pin later switched to output drives the stored value.
- R3: A write to address 0x05 (direction register) or 0x28 (takeover register) loads that register on the clock edge. Reading the same address returns the stored byte.
- R4: When a pin's direction bit is 1 and its takeover bit is 0, `pad_oe` is 1 for that pin, `pad_out` equals its latch bit, and a read of 0x01 returns the latch bit.
- R5: When a pin's direction bit is 0 and its takeover bit is 0, `pad_oe` is 0 for that pin, and a read of 0x01 returns the synchronized pin level.
- R6: A change on `pad_in` shows in reads of 0x01 after exactly two rising clock edges and not after one.
- R7: When takeover bit x is 1, `pad_out[x]` follows `pwm_wave[x]` combinationally, `pad_oe[x]` is 1 whatever the direction bit is, and a read of 0x01 returns `pwm_wave[x]` for that bit.
- R8: Writes to any address other than 0x01, 0x05 and 0x28 change no register. Reads of such addresses return 0x00.
- R9: Reads of 0x01 combine the per-bit sources independently, so a mixed direction byte returns latch bits and pin bits in their own positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Raw pin levels from the pads |
| pwm_wave | input | 8 | PWM waveform bit per pin |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Output enable for each pad |

## Verification
A register write lands on the first rising edge after the strobe. Its effect on `pad_out`, `pad_oe` and read data is therefore checked once that edge has passed. Because reads are combinational, the bench sets the address on the falling edge and samples one nanosecond later. A pin change needs two rising edges to reach read data. The bench samples once after one edge, expecting the old value, and again after the second, expecting the new one. PWM takeover needs no clock, so after a waveform change the bench checks `pad_out` within the same cycle.

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port #(
  parameter int W = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h01,
  parameter logic [AW-1:0] DIR_ADDR  = 8'h05,
  parameter logic [AW-1:0] PWM_ADDR  = 8'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  input  logic [W-1:0]  pwm_wave,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe
);

  logic [W-1:0] latch_q, dir_q, pwm_en_q, sync1_q, sync2_q, pin_view;
  logic hit_data, hit_dir, hit_pwm;

  assign hit_data = bus_addr == DATA_ADDR;
  assign hit_dir  = bus_addr == DIR_ADDR;
  assign hit_pwm  = bus_addr == PWM_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      dir_q    <= '0;
      pwm_en_q <= '0;
      sync1_q  <= '0;
      sync2_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_we && hit_data) latch_q  <= bus_wdata;
      if (bus_we && hit_dir)  dir_q    <= bus_wdata;
      if (bus_we && hit_pwm)  pwm_en_q <= bus_wdata;
    end
  end

  assign pad_out  = (pwm_en_q & pwm_wave) | (~pwm_en_q & latch_q);
  assign pad_oe   = pwm_en_q | dir_q;
  assign pin_view = (pwm_en_q & pwm_wave)
                  | (~pwm_en_q & dir_q & latch_q)
                  | (~pwm_en_q & ~dir_q & sync2_q);

  always_comb begin
    bus_rdata = '0;
    if (hit_data)     bus_rdata = pin_view;
    else if (hit_dir) bus_rdata = dir_q;
    else if (hit_pwm) bus_rdata = pwm_en_q;
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_data) |=> (((pad_out ^ $past(bus_wdata)) & ~pwm_en_q) == '0));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_dir) |=> (dir_q == $past(bus_wdata)));

  // R8
  unmapped_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit_data && !hit_dir && !hit_pwm)
      |=> ($stable(latch_q) && $stable(dir_q) && $stable(pwm_en_q)));

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (sync2_q == $past(pad_in, 2)));

  // R7
  pwm_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pwm_en_q) == pwm_en_q) && (((pad_out ^ pwm_wave) & pwm_en_q) == '0));

endmodule

// File: tb/gpio_pwm_port_test.sv
module gpio_pwm_port_test;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, pad_in = 0, pwm_wave = 0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  gpio_pwm_port uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pwm_wave(pwm_wave),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(8'h01, d); check("R1 data", d, 8'h00);
    rd(8'h05, d); check("R1 dir", d, 8'h00);
    rd(8'h28, d); check("R1 pwm", d, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
  endtask

  task automatic t_output;
    logic [7:0] d;
    wr(8'h05, 8'hFF);
    rd(8'h05, d); check("R3 dir readback", d, 8'hFF);
    wr(8'h01, 8'hA5);
    rd(8'h01, d); check("R4 read latch", d, 8'hA5);
    check("R4 pad_out", pad_out, 8'hA5);
    check("R4 pad_oe", pad_oe, 8'hFF);
  endtask

  task automatic t_input;
    logic [7:0] d;
    wr(8'h05, 8'h00);
    check("R5 oe off", pad_oe, 8'h00);
    @(negedge clk); pad_in = 8'h3C; bus_addr = 8'h01;
    @(negedge clk); #1 check("R6 one edge", bus_rdata, 8'h00);
    @(negedge clk); #1 check("R6 two edges", bus_rdata, 8'h3C);
    rd(8'h01, d); check("R5 pin read", d, 8'h3C);
  endtask

  task automatic t_latch_hidden;
    logic [7:0] d;
    wr(8'h01, 8'hC3);
    check("R5 still hiz", pad_oe, 8'h00);
    rd(8'h01, d); check("R5 reads pin not latch", d, 8'h3C);
    wr(8'h05, 8'hFF);
    check("R2 stored value driven", pad_out, 8'hC3);
    check("R2 oe", pad_oe, 8'hFF);
  endtask

  task automatic t_mixed;
    logic [7:0] d;
    wr(8'h05, 8'hF0);
    wr(8'h01, 8'h5A);
    @(negedge clk); pad_in = 8'h33;
    repeat (3) @(negedge clk);
    rd(8'h01, d); check("R9 mixed read", d, 8'h53);
    check("R9 mixed oe", pad_oe, 8'hF0);
  endtask

  task automatic t_pwm;
    logic [7:0] d;
    wr(8'h05, 8'h00);
    wr(8'h01, 8'h90);
    @(negedge clk); pwm_wave = 8'hA6;
    wr(8'h28, 8'h0F);
    rd(8'h28, d); check("R3 pwm readback", d, 8'h0F);
    check("R7 oe forced", pad_oe, 8'h0F);
    check("R7 pad_out", pad_out, 8'h96);
    rd(8'h01, d); check("R7 read", d, 8'h36);
    @(negedge clk); pwm_wave = 8'h59; #1
    check("R7 follows wave", pad_out, 8'h99);
    wr(8'h05, 8'hFF);
    check("R7 over dir", pad_out, 8'h99);
    wr(8'h28, 8'h00);
    check("R7 released", pad_out, 8'h90);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'h02, 8'hFF);
    wr(8'h29, 8'h55);
    rd(8'h02, d); check("R8 read unmapped", d, 8'h00);
    rd(8'h01, d); check("R8 latch kept", d, 8'h90);
    rd(8'h05, d); check("R8 dir kept", d, 8'hFF);
    rd(8'h28, d); check("R8 pwm kept", d, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_output; t_input; t_latch_hidden; t_mixed; t_pwm; t_unmapped;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule